// File: doc/BRIEF.md
# Per-Address Two-Level Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It works in two stages. The first stage is a table of per-branch outcome histories, selected by address bits of the branch. Each entry is a short shift register that holds the most recent directions of the branches mapped to it. The second stage is a single table of 2-bit saturating counters. Every branch shares this table, and the history value read in the first stage selects the counter. The prediction is the upper bit of that counter.

The fetch side presents an address and reads the prediction in the same cycle, through purely combinational logic. The resolve side reports a branch's real direction with a valid strobe. On that clock edge the block trains the counter chosen by the branch's old history, then shifts the outcome into that history.

Top module: `pag_predictor`

## Requirements
- R1: After reset, every history entry is all zeros and every counter holds 2'b01 (weakly not-taken). Every lookup therefore predicts not-taken until training begins.
- R2: `pred_taken` is bit 1 of the counter selected by the history entry of `lookup_pc`. It responds combinationally, in the same cycle as the address.
- R3: On an update with `update_taken`=1, the selected counter increments and stays at 2'b11 once it gets there.
- R4: On an update with `update_taken`=0, the selected counter decrements and stays at 2'b00 once it gets there.
- R5: An update first trains the counter chosen by the branch's old history. It then shifts `update_taken` into bit 0 of that history, moves the older bits up one place, and drops bit 5.
- R6: The counter table is indexed by the history value only. Two branches whose histories are equal read and train the same counter.
- R7: The history entry is chosen by address bits [7:2]. Addresses that differ only in bits [1:0] or in bits above 7 share one entry.
- R8: While `update_valid` is 0, neither table changes, whatever `update_pc` and `update_taken` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lookup_pc | input | 32 | Address of the branch being fetched |
| pred_taken | output | 1 | Predicted direction for `lookup_pc` (1 = taken) |
| update_valid | input | 1 | Strobe: a resolved outcome is present this cycle |
| update_pc | input | 32 | Address of the resolved branch |
| update_taken | input | 1 | Real direction of the resolved branch |

## Verification
A prediction belongs to the cycle in which its address is presented, so the bench drives `lookup_pc` on the falling edge and compares `pred_taken` a nanosecond later, before the next rising edge. An update takes effect on the rising edge where its strobe is seen. The bench's behavioural model applies the same update right after that edge, so the first comparison that can show the change is the one in the following cycle. A lookup and an update presented in the same cycle, to the same branch, must therefore still see the state from before that update.

// File: rtl/pag_predictor.sv
module pag_predictor #(
  parameter int PC_W    = 32,
  parameter int IDX_LSB = 2,
  parameter int IDX_W   = 6,
  parameter int HIST_W  = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lookup_pc,
  output logic            pred_taken,
  input  logic            update_valid,
  input  logic [PC_W-1:0] update_pc,
  input  logic            update_taken
);
  localparam int BHT_N = 1 << IDX_W;
  localparam int PHT_N = 1 << HIST_W;

  logic [BHT_N-1:0][HIST_W-1:0] bht_q;
  logic [PHT_N-1:0][1:0]        pht_q;

  logic [IDX_W-1:0]  lk_idx, up_idx;
  logic [HIST_W-1:0] up_hist;
  logic [1:0]        up_ctr, up_ctr_nxt;

  assign lk_idx     = lookup_pc[IDX_LSB +: IDX_W];
  assign up_idx     = update_pc[IDX_LSB +: IDX_W];
  assign up_hist    = bht_q[up_idx];
  assign up_ctr     = pht_q[up_hist];
  assign pred_taken = pht_q[bht_q[lk_idx]][1];

  always_comb begin
    if (update_taken) up_ctr_nxt = (up_ctr == 2'b11) ? 2'b11 : up_ctr + 2'b01;
    else              up_ctr_nxt = (up_ctr == 2'b00) ? 2'b00 : up_ctr - 2'b01;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bht_q <= '0;
      pht_q <= {PHT_N{2'b01}};
    end else if (update_valid) begin
      pht_q[up_hist] <= up_ctr_nxt;
      bht_q[up_idx]  <= {up_hist[HIST_W-2:0], update_taken};
    end
  end

  AST_CTR_SAT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (update_valid && update_taken && up_ctr == 2'b11) |=> pht_q[$past(up_hist)] == 2'b11); // R3
  AST_CTR_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (update_valid && update_taken && up_ctr != 2'b11) |=> pht_q[$past(up_hist)] == $past(up_ctr) + 2'b01); // R3
  AST_CTR_SAT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (update_valid && !update_taken && up_ctr == 2'b00) |=> pht_q[$past(up_hist)] == 2'b00); // R4
  AST_CTR_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (update_valid && !update_taken && up_ctr != 2'b00) |=> pht_q[$past(up_hist)] == $past(up_ctr) - 2'b01); // R4
  AST_HIST_LSB: assert property (@(posedge clk) disable iff (!rst_n)
    update_valid |=> bht_q[$past(up_idx)][0] == $past(update_taken)); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !update_valid |=> ($stable(bht_q) && $stable(pht_q))); // R8
endmodule

// File: tb/pag_predictor_tb.sv
`timescale 1ns/1ps
module pag_predictor_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lookup_pc = '0;
  logic        pred_taken;
  logic        update_valid = 1'b0;
  logic [31:0] update_pc = '0;
  logic        update_taken = 1'b0;

  int checks = 0;
  int fails  = 0;
  int m_hist [64];
  int m_ctr  [64];

  always #4 clk = ~clk;

  pag_predictor u_dut (
    .clk(clk), .rst_n(rst_n), .lookup_pc(lookup_pc), .pred_taken(pred_taken),
    .update_valid(update_valid), .update_pc(update_pc), .update_taken(update_taken)
  );

  task automatic step(input string req, input logic [31:0] lpc, input logic uv,
                      input logic [31:0] upc, input logic ut);
    logic exp;
    int   ix, h;
    @(negedge clk);
    lookup_pc = lpc; update_valid = uv; update_pc = upc; update_taken = ut;
    #1;
    exp = (m_ctr[m_hist[(lpc >> 2) & 63]] >= 2);
    checks++;
    if (pred_taken !== exp) begin
      fails++;
      $display("FAIL %s pc=%h actual=%b expected=%b", req, lpc, pred_taken, exp);
    end
    @(posedge clk);
    if (uv) begin
      ix = (upc >> 2) & 63;
      h  = m_hist[ix];
      if (ut) m_ctr[h] = (m_ctr[h] == 3) ? 3 : m_ctr[h] + 1;
      else    m_ctr[h] = (m_ctr[h] == 0) ? 0 : m_ctr[h] - 1;
      m_hist[ix] = ((h << 1) | int'(ut)) & 63;
    end
  endtask

  initial begin
    #1500000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) begin m_hist[i] = 0; m_ctr[i] = 1; end
    #20;
    checks++;
    if (pred_taken !== 1'b0) begin
      fails++;
      $display("FAIL R1 in reset actual=%b expected=0", pred_taken);
    end
    @(negedge clk); rst_n = 1'b1;

    // R1: all lookups predict not-taken after reset
    for (int i = 0; i < 64; i++) step("R1", 32'(i * 4), 1'b0, '0, 1'b0);
    // R3: repeated taken saturates counters high
    for (int i = 0; i < 14; i++) step("R3", 32'h40, 1'b1, 32'h40, 1'b1);
    // R4: repeated not-taken saturates counters low
    for (int i = 0; i < 14; i++) step("R4", 32'h40, 1'b1, 32'h40, 1'b0);
    // R5: alternating pattern, lookup and update together on the same branch
    for (int i = 0; i < 20; i++) step("R5", 32'h84, 1'b1, 32'h84, 1'(i % 2));
    // R6: branch D inherits counters trained by branch C once histories match
    for (int i = 0; i < 10; i++) step("R6", 32'h20, 1'b1, 32'h10, 1'b1);
    for (int i = 0; i < 8; i++)  step("R6", 32'h20, 1'b1, 32'h20, 1'b1);
    // R7: aliasing addresses share one history entry
    for (int i = 0; i < 10; i++) step("R7", 32'h0000_010B, 1'b1, 32'hABCD_0108, 1'b1);
    for (int i = 0; i < 4; i++)  step("R7", 32'h5500_0109, 1'b1, 32'h0000_0108, 1'b0);
    // R8: strobe low, update fields busy
    for (int i = 0; i < 40; i++)
      step("R8", 32'(($urandom % 64) * 4), 1'b0, 32'($urandom), 1'($urandom));
    // R2: mixed traffic over a small branch set
    for (int i = 0; i < 600; i++)
      step("R2", 32'(($urandom % 12) * 4), 1'($urandom % 4 != 0),
           32'(($urandom % 12) * 4), 1'($urandom % 3 != 0));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule